// File: doc/BRIEF.md
# Reset Cause Flag Register

This block records which internal event triggered the latest reset of the chip and presents the result as one 8-bit status register on a small synchronous register bus. Seven detectors each deliver a one-cycle pulse on a shared source vector. The matching sticky flag is set, and it stays set through later internal resets, so boot code can read why the chip restarted. Only a power-on reset (`rst_n`) or an external pin reset (`ext_rst_n`) wipes the register.

Software cannot clear the flags with a single store. It must first arm the clear by writing 1 to bit 7 of the flag register. It must then write the key value 0x71 to a separate control register. The key takes effect only while the CPU clock select input reports the divide-by-4 setting (`clk_sel` = 2'b00). A successful key write zeroes every flag and drops the arm bit. An internal reset keeps the flags but drops the arm bit, so a half-finished clear sequence does not survive it.

Top module: `rst_cause_flags`

## Requirements
- R1: Source pulse bit i sets flag bit i of the flag register at the next clock edge. The bit positions are: 0 watchdog, 1 system clock fault, 2 voltage detect 1, 3 voltage detect 2, 4 trimming-data reset, 5 trimming-data abnormal status, 6 flash standby reset.
- R2: A set flag stays at 1 until a keyed clear, a power-on reset or an external reset.
- R3: Bit 7 of the flag register always reads 0. A write to the flag register never changes bits 0 to 6.
- R4: While `rst_n` or `ext_rst_n` is low at a clock edge, all flags, the arm bit and `rdata` go to 0.
- R5: A high `int_rst` leaves every flag unchanged and drops the arm bit.
- R6: Clearing is a two-step sequence. First, a write to `FLAG_ADDR` with bit 7 set arms the clear. Then a write of 0x71 to `CTRL_ADDR` with `clk_sel` = 2'b00 clears all flags and the arm bit at the next edge.
- R7: A key write while the clear is not armed has no effect on the flags.
- R8: A key write while `clk_sel` is not 2'b00 is ignored: the flags are kept and the arm bit stays set.
- R9: A write of any value other than 0x71 to `CTRL_ADDR` keeps both the flags and the arm bit.
- R10: A source pulse in the same cycle as a successful keyed clear leaves its flag set.
- R11: `rdata` shows {0, flags} one cycle after `addr` = `FLAG_ADDR` is presented, and shows 0 for any other address.
- R12: A write to `FLAG_ADDR` with bit 7 = 0 disarms a pending clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| ext_rst_n | input | 1 | External pin reset, synchronous, active low |
| int_rst | input | 1 | Internal-factor reset in progress, active high |
| src_pulse | input | 7 | One-cycle detection pulses, one bit per source |
| clk_sel | input | 2 | CPU clock select; 2'b00 means input clock / 4 |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
The assertions assume that `rst_n` is held low from time zero until the first edges have passed. They also assume that `src_pulse`, `wr_en`, `addr`, `wdata` and `clk_sel` are stable across each rising edge, since these inputs come from logic in the same clock domain. The bench drives every input on the falling edge and draws pulses, writes, key values, clock selects and resets from `$urandom` with a fixed seed. It biases the address toward the two live registers and the control data toward the key, so that armed, keyed and locked-out clears all occur often. The random phase keeps `rst_n` high and uses `ext_rst_n` and `int_rst` as the reset events.

// File: rtl/rcf_pkg.sv
// Package: shared sizes and types for the reset cause flag register.
// Assumes: one flag per detector; the register is 8 bits wide, with the arm bit on top.
package rcf_pkg;
    localparam int unsigned NUM_SRC = 7;
    localparam int unsigned REG_W   = NUM_SRC + 1;
    localparam int unsigned ARM_BIT = REG_W - 1;

    // Positions of each detector in the flag vector.
    typedef enum int unsigned {
        SRC_WDOG   = 0,
        SRC_CLKF   = 1,
        SRC_VDET1  = 2,
        SRC_VDET2  = 3,
        SRC_TRIMR  = 4,
        SRC_TRIMBAD = 5,
        SRC_FLSTBY = 6
    } src_idx_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;
    typedef logic [REG_W-1:0]   reg_t;
endpackage

// File: rtl/rcf_decode.sv
// Module: rcf_decode
// Decodes register-bus writes into an arm update and a qualified keyed clear.
// Assumes: inputs are synchronous to the block clock; purely combinational.
module rcf_decode
    import rcf_pkg::*;
#(
    parameter int unsigned      ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'hC0,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hC4,
    parameter logic [REG_W-1:0]  KEY       = 8'h71,
    parameter int unsigned      SEL_W     = 2,
    parameter logic [SEL_W-1:0] SEL_OK    = '0
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  reg_t              wdata,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic              arm_q,
    output logic              arm_wr,
    output logic              arm_val,
    output logic              key_clear
);
    // Purpose: recognise a flag-register write and a fully qualified key write.
    always_comb begin
        arm_wr    = wr_en && (addr == FLAG_ADDR);
        arm_val   = wdata[ARM_BIT];
        key_clear = wr_en && (addr == CTRL_ADDR) && (wdata == KEY)
                    && (clk_sel == SEL_OK) && arm_q;
    end
endmodule

// File: rtl/rcf_arm.sv
// Module: rcf_arm
// Holds the write-only arm bit of the keyed clear sequence.
// Assumes: rst_n and ext_rst_n are synchronous active-low; int_rst is active-high.
module rcf_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_rst_n,
    input  logic int_rst,
    input  logic arm_wr,
    input  logic arm_val,
    input  logic key_clear,
    output logic arm_q
);
    // Purpose: set or drop the arm bit; a used key or an internal reset drops it.
    always_ff @(posedge clk) begin
        if (!rst_n || !ext_rst_n) begin
            arm_q <= 1'b0;
        end else if (key_clear || int_rst) begin
            arm_q <= 1'b0;
        end else if (arm_wr) begin
            arm_q <= arm_val;
        end
    end
endmodule

// File: rtl/rcf_flag_bank.sv
// Module: rcf_flag_bank
// One sticky flag per reset source. Internal resets do not reach it.
// Assumes: src_pulse bits are one-cycle pulses; set has priority over clear.
module rcf_flag_bank
    import rcf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ext_rst_n,
    input  src_vec_t src_pulse,
    input  logic     key_clear,
    output src_vec_t flags_q
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
        // Purpose: latch source i; a keyed clear keeps any same-cycle pulse.
        always_ff @(posedge clk) begin
            if (!rst_n || !ext_rst_n) begin
                flags_q[i] <= 1'b0;
            end else if (key_clear) begin
                flags_q[i] <= src_pulse[i];
            end else begin
                flags_q[i] <= flags_q[i] | src_pulse[i];
            end
        end
    end
endmodule

// File: rtl/rst_cause_flags.sv
// Module: rst_cause_flags (top)
// Reset cause flag register with a keyed, clock-gated software clear.
// Assumes: single clock domain; reads return data one cycle after the address.
module rst_cause_flags
    import rcf_pkg::*;
#(
    parameter int unsigned      ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'hC0,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hC4,
    parameter logic [REG_W-1:0]  KEY       = 8'h71,
    parameter int unsigned      SEL_W     = 2,
    parameter logic [SEL_W-1:0] SEL_OK    = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_rst_n,
    input  logic              int_rst,
    input  logic [6:0]        src_pulse,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    logic     arm_q;
    logic     arm_wr;
    logic     arm_val;
    logic     key_clear;
    src_vec_t flags_q;

    rcf_decode #(
        .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR), .CTRL_ADDR(CTRL_ADDR),
        .KEY(KEY), .SEL_W(SEL_W), .SEL_OK(SEL_OK)
    ) u_decode (
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .clk_sel(clk_sel),
        .arm_q(arm_q), .arm_wr(arm_wr), .arm_val(arm_val), .key_clear(key_clear)
    );

    rcf_arm u_arm (
        .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .int_rst(int_rst),
        .arm_wr(arm_wr), .arm_val(arm_val), .key_clear(key_clear), .arm_q(arm_q)
    );

    rcf_flag_bank u_flags (
        .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n),
        .src_pulse(src_pulse), .key_clear(key_clear), .flags_q(flags_q)
    );

    // Purpose: registered read port; the arm bit is write-only and reads 0.
    always_ff @(posedge clk) begin
        if (!rst_n || !ext_rst_n) begin
            rdata <= '0;
        end else if (addr == FLAG_ADDR) begin
            rdata <= {1'b0, flags_q};
        end else begin
            rdata <= '0;
        end
    end
endmodule

// File: rtl/rcf_checker.sv
// Module: rcf_checker
// Temporal checks on the reset cause flag register, bound to the top module.
// Assumes: rst_n is low from time zero; inputs are stable around the rising edge.
module rcf_checker #(
    parameter int unsigned      ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'hC0,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hC4,
    parameter logic [7:0]        KEY       = 8'h71,
    parameter int unsigned      SEL_W     = 2,
    parameter logic [SEL_W-1:0] SEL_OK    = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ext_rst_n,
    input logic              int_rst,
    input logic [6:0]        src_pulse,
    input logic [SEL_W-1:0]  clk_sel,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [7:0]        wdata,
    input logic [7:0]        rdata,
    input logic [6:0]        flags_q,
    input logic              arm_q,
    input logic              key_clear
);
    assert_pulse_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rst_n && (src_pulse != '0)) |=> ((flags_q & $past(src_pulse)) == $past(src_pulse)));

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(flags_q) & ~flags_q) != '0)) |-> ($past(key_clear) || !$past(ext_rst_n)));

    assert_bit7_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[7] == 1'b0);

    assert_ext_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rst_n |=> (flags_q == '0 && !arm_q && rdata == '0));

    assert_int_reset_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (int_rst && ext_rst_n && !key_clear) |=> ((flags_q & $past(flags_q)) == $past(flags_q) && !arm_q));

    assert_locked_key_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CTRL_ADDR && wdata == KEY && clk_sel != SEL_OK
         && arm_q && ext_rst_n && !int_rst) |=> arm_q);

    assert_read_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rst_n && addr == FLAG_ADDR) |=> (rdata == {1'b0, $past(flags_q)}));

    assert_other_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != FLAG_ADDR) |=> (rdata == '0));
endmodule

bind rst_cause_flags rcf_checker #(
    .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR), .CTRL_ADDR(CTRL_ADDR),
    .KEY(KEY), .SEL_W(SEL_W), .SEL_OK(SEL_OK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .int_rst(int_rst),
    .src_pulse(src_pulse), .clk_sel(clk_sel), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .flags_q(flags_q), .arm_q(arm_q),
    .key_clear(key_clear)
);

// File: tb/rst_cause_flags_bench.sv
// Bench: self-checking, directed corner cases followed by seeded random stimulus.
module rst_cause_flags_bench;
    localparam logic [7:0] FA  = 8'hC0;
    localparam logic [7:0] CA  = 8'hC4;
    localparam logic [7:0] KEY = 8'h71;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       int_rst = 1'b0;
    logic [6:0] src_pulse = '0;
    logic [1:0] clk_sel = 2'b00;
    logic [7:0] addr = 8'h00;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [6:0] m_flags = '0;
    logic       m_arm = 1'b0;
    logic [7:0] exp_rd = '0;

    always #2.5 clk = ~clk;

    rst_cause_flags u_rst_cause_flags (
        .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .int_rst(int_rst),
        .src_pulse(src_pulse), .clk_sel(clk_sel), .addr(addr), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata)
    );

    // Model of the next read value, built from the requirements.
    function automatic logic [7:0] model_read();
        if (!rst_n || !ext_rst_n) return 8'h00;
        return (addr == FA) ? {1'b0, m_flags} : 8'h00;
    endfunction

    // Model of the flag and arm state after one clock edge.
    task automatic model_step();
        logic key;
        if (!rst_n || !ext_rst_n) begin
            m_flags = '0;
            m_arm   = 1'b0;
        end else begin
            key = wr_en && addr == CA && wdata == KEY && clk_sel == 2'b00 && m_arm;
            m_flags = key ? src_pulse : (m_flags | src_pulse);
            if (key || int_rst) m_arm = 1'b0;
            else if (wr_en && addr == FA) m_arm = wdata[7];
        end
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: rdata=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle();
        int_rst = 1'b0; src_pulse = '0; wr_en = 1'b0; wdata = 8'h00;
        addr = FA; clk_sel = 2'b00; ext_rst_n = 1'b1;
    endtask

    // One cycle with the inputs as driven; check rdata against the model.
    task automatic tick(input string req);
        exp_rd = model_read();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(req, rdata, exp_rd);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic [1:0] sel,
                      input logic [6:0] p, input string req);
        idle(); wr_en = 1'b1; addr = a; wdata = d; clk_sel = sel; src_pulse = p;
        tick(req);
        idle();
    endtask

    // Read the flag register and compare with a fixed value from the requirement.
    task automatic rd_const(input string req, input logic [7:0] exp);
        idle(); addr = FA;
        tick(req);
        check(req, rdata, exp);
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                bad++; total++;
                $display("FAIL watchdog: cycles=%0d expected<=150000", cycles);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin : stim
        idle();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) tick("R4 power-on reset");
        rst_n = 1'b1;
        rd_const("R4 reset state", 8'h00);

        // R1: each source sets its own bit; R2: earlier bits stay.
        for (int i = 0; i < 7; i++) begin
            idle(); src_pulse = 7'(1 << i); tick("R1 pulse");
            idle();
            rd_const("R1 R2 accumulate", 8'((2 << i) - 1));
        end

        // R3: a flag-register write with bit 7 clear leaves bits 0-6.
        wr(FA, 8'h00, 2'b00, '0, "R3 write");
        rd_const("R3 write ignored", 8'h7F);
        wr(FA, 8'h80, 2'b00, '0, "R3 arm");
        rd_const("R3 bit7 reads 0", 8'h7F);

        // R6: armed key with clock select 00 clears.
        wr(CA, KEY, 2'b00, '0, "R6 key");
        rd_const("R6 cleared", 8'h00);

        // R7: key without arming does nothing.
        idle(); src_pulse = 7'h05; tick("R7 set"); idle();
        wr(CA, KEY, 2'b00, '0, "R7 key");
        rd_const("R7 unarmed key", 8'h05);

        // R8: wrong clock select ignores key, arm survives.
        wr(FA, 8'h80, 2'b00, '0, "R8 arm");
        wr(CA, KEY, 2'b01, '0, "R8 key");
        rd_const("R8 locked", 8'h05);
        wr(CA, KEY, 2'b00, '0, "R8 key ok");
        rd_const("R8 arm retained", 8'h00);

        // R9: non-key data keeps arm and flags.
        idle(); src_pulse = 7'h40; tick("R9 set"); idle();
        wr(FA, 8'h80, 2'b00, '0, "R9 arm");
        wr(CA, 8'h70, 2'b00, '0, "R9 bad key");
        rd_const("R9 kept", 8'h40);
        wr(CA, KEY, 2'b00, '0, "R9 key");
        rd_const("R9 arm retained", 8'h00);

        // R10: pulse on the clearing cycle survives.
        idle(); src_pulse = 7'h11; tick("R10 set"); idle();
        wr(FA, 8'h80, 2'b00, '0, "R10 arm");
        wr(CA, KEY, 2'b00, 7'h08, "R10 key+pulse");
        rd_const("R10 set wins", 8'h08);

        // R12: writing bit 7 = 0 disarms.
        wr(FA, 8'h80, 2'b00, '0, "R12 arm");
        wr(FA, 8'h00, 2'b00, '0, "R12 disarm");
        wr(CA, KEY, 2'b00, '0, "R12 key");
        rd_const("R12 disarmed", 8'h08);

        // R5: internal reset keeps flags, drops arm.
        wr(FA, 8'h80, 2'b00, '0, "R5 arm");
        idle(); int_rst = 1'b1; tick("R5 int reset"); idle();
        rd_const("R5 flags kept", 8'h08);
        wr(CA, KEY, 2'b00, '0, "R5 key");
        rd_const("R5 arm dropped", 8'h08);

        // R11: other address reads 0.
        idle(); addr = 8'h33; tick("R11 other");
        check("R11 other addr", rdata, 8'h00);

        // R4: external reset clears.
        idle(); ext_rst_n = 1'b0; tick("R4 ext reset"); idle();
        rd_const("R4 ext cleared", 8'h00);

        // Random phase.
        void'($urandom(32'h5EED_0042));
        for (int n = 0; n < 4000; n++) begin
            int r;
            idle();
            src_pulse = 7'($urandom & $urandom & $urandom);
            int_rst   = ($urandom_range(0, 19) == 0);
            ext_rst_n = ($urandom_range(0, 39) != 0);
            clk_sel   = ($urandom_range(0, 9) < 7) ? 2'b00 : 2'($urandom_range(1, 3));
            r = $urandom_range(0, 9);
            addr = (r < 5) ? FA : (r < 9) ? CA : 8'($urandom);
            wr_en = $urandom_range(0, 1) == 1;
            if (addr == CA) wdata = ($urandom_range(0, 1) == 1) ? KEY : 8'($urandom);
            else wdata = ($urandom_range(0, 2) == 0) ? 8'h80 : 8'($urandom);
            tick("R11 random read");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule